// File: doc/BRIEF.md
# Two-Tone FSK Receiver with Carrier Detect

This block turns a stream of 12-bit offset-binary ADC samples, taken at eight samples per bit (9600 samples/s for a 1200 bit/s line), into a recovered serial data level and a carrier-present flag. The ADC code 2048 stands for the mid-scale bias point, so the block recentres each sample by inverting its top bit. It then correlates the newest eight samples, one bit time, against quadrature references at 1200 Hz and at 2200 Hz. It compares the two squared magnitudes and reports a 1 when the 1200 Hz energy is larger.

Signal level is tracked as the peak-to-peak span of the newest sixteen samples. A comparator with two thresholds turns that span into the carrier flag. While the flag is low, the data output rests at 1, which a downstream UART sees as an idle line. Character framing is left to that UART.

Receive is enabled by `rx_on`. While it is low, all internal state is held cleared and incoming samples are discarded. The block therefore starts from a clean state each time receive mode is entered.

Top module: `fsk_demod`

## Requirements
- R1: A tone near 1200 Hz that fills the 8-sample window, with carrier asserted, gives `rx_data` = 1 within two clocks of the window's last sample strobe.
- R2: A tone near 2200 Hz that fills the 8-sample window, with carrier asserted, gives `rx_data` = 0 within two clocks of the window's last sample strobe.
- R3: An 11-bit character (start 0, eight data bits LSB first, even parity, stop 1), sent as phase-continuous tones at 8 samples per bit, is reproduced bit for bit on `rx_data` at the end of every bit.
- R4: `carrier` goes to 1 after a sample window whose peak-to-peak span exceeds 400 codes.
- R5: `carrier` goes to 0 after a sample window whose peak-to-peak span is below 266 codes.
- R6: While the span stays from 266 to 400 codes inclusive, `carrier` keeps its previous value, whether that value is 0 or 1.
- R7: While `rx_on` is 0, `rx_data` is 1, `carrier` is 0, and sample strobes have no effect on later behaviour.
- R8: When `rx_on` rises, the block starts cleared: `carrier` is 0 and `rx_data` is 1 until new samples arrive, regardless of the state held before receive was disabled.
- R9: While `carrier` is 0, `rx_data` is 1 (idle mark), whichever tone is present.
- R10: After reset, `rx_data` is 1 and `carrier` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_on | input | 1 | 1 selects receive; 0 holds the receiver cleared |
| smp_vld | input | 1 | One-cycle strobe marking a new ADC sample |
| smp | input | 12 | Offset-binary ADC code, 2048 = bias point |
| rx_data | output | 1 | Recovered data level, 1 = 1200 Hz or idle |
| carrier | output | 1 | Carrier present, with hysteresis |

## Verification
Strong runs of constant mark and constant space show that each correlator wins on its own tone. Full characters, which contain back-to-back changes of tone, show that phase-continuous switching is resolved within one bit window. Amplitude steps from strong to mid-band, then to weak, then back to mid-band and strong, separate the two thresholds and show that the mid-band level holds either state. A strong tone applied while receive is disabled, followed by re-entry, shows that nothing was absorbed while the receiver was off.

// File: rtl/fsk_demod.sv
module fsk_demod #(
  parameter int SW    = 12,
  parameter int PPW   = 16,
  parameter int TH_HI = 400,
  parameter int TH_LO = 266
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          smp_vld,
  input  logic [SW-1:0] smp,
  output logic          rx_data,
  output logic          carrier
);
  localparam int WIN = 8;
  localparam int CW  = 8;
  localparam int AW  = SW + CW + $clog2(WIN) + 1;
  localparam int EW  = 2 * AW + 1;

  localparam logic signed [CW-1:0] MK_C [WIN] = '{8'sd64, 8'sd45, 8'sd0, -8'sd45, -8'sd64, -8'sd45, 8'sd0, 8'sd45};
  localparam logic signed [CW-1:0] MK_S [WIN] = '{8'sd0, 8'sd45, 8'sd64, 8'sd45, 8'sd0, -8'sd45, -8'sd64, -8'sd45};
  localparam logic signed [CW-1:0] SP_C [WIN] = '{8'sd64, 8'sd8, -8'sd62, -8'sd24, 8'sd55, 8'sd39, -8'sd45, -8'sd51};
  localparam logic signed [CW-1:0] SP_S [WIN] = '{8'sd0, 8'sd63, 8'sd17, -8'sd59, -8'sd32, 8'sd51, 8'sd45, -8'sd39};

  logic signed [SW-1:0] win [PPW];
  logic                 vld_q;
  logic                 dec;
  logic signed [SW-1:0] cen;
  logic signed [AW-1:0] mi, mq, si, sq;
  logic        [EW-1:0] e_mk, e_sp;
  logic signed [SW-1:0] mx, mn;
  logic signed [SW:0]   pp;

  assign cen = {~smp[SW-1], smp[SW-2:0]};

  always_comb begin
    mi = '0; mq = '0; si = '0; sq = '0;
    for (int j = 0; j < WIN; j++) begin
      mi = mi + AW'(win[j]) * AW'(MK_C[j]);
      mq = mq + AW'(win[j]) * AW'(MK_S[j]);
      si = si + AW'(win[j]) * AW'(SP_C[j]);
      sq = sq + AW'(win[j]) * AW'(SP_S[j]);
    end
    e_mk = EW'(EW'(mi) * EW'(mi)) + EW'(EW'(mq) * EW'(mq));
    e_sp = EW'(EW'(si) * EW'(si)) + EW'(EW'(sq) * EW'(sq));
  end

  always_comb begin
    mx = win[0];
    mn = win[0];
    for (int i = 1; i < PPW; i++) begin
      if (win[i] > mx) mx = win[i];
      if (win[i] < mn) mn = win[i];
    end
    pp = {mx[SW-1], mx} - {mn[SW-1], mn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PPW; i++) win[i] <= '0;
      vld_q   <= 1'b0;
      dec     <= 1'b1;
      carrier <= 1'b0;
    end else if (!rx_on) begin
      for (int i = 0; i < PPW; i++) win[i] <= '0;
      vld_q   <= 1'b0;
      dec     <= 1'b1;
      carrier <= 1'b0;
    end else begin
      vld_q <= smp_vld;
      if (smp_vld) begin
        win[0] <= cen;
        for (int i = 1; i < PPW; i++) win[i] <= win[i-1];
      end
      if (vld_q) begin
        dec <= (e_mk > e_sp);
        if (pp > TH_HI)      carrier <= 1'b1;
        else if (pp < TH_LO) carrier <= 1'b0;
      end
    end
  end

  assign rx_data = carrier ? dec : 1'b1;

  // R4
  cd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> ($past(pp) > TH_HI));

  // R5
  cd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier) |-> (($past(pp) < TH_LO) || !$past(rx_on)));

  // R6
  cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && vld_q && pp >= TH_LO && pp <= TH_HI) |=> $stable(carrier));

  // R7
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> (rx_data && !carrier && pp == 0));

endmodule

// File: tb/fsk_demod_bench.sv
module fsk_demod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_on = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp = 12'd2048;
  logic        rx_data, carrier;

  always #5 clk = ~clk;

  fsk_demod u_fsk_demod (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .smp_vld(smp_vld),
    .smp(smp), .rx_data(rx_data), .carrier(carrier)
  );

  typedef struct {
    bit    chk_d;
    bit    exp_d;
    bit    chk_c;
    bit    exp_c;
    string tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  real   ph = 0.3927;

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk_d) begin
          checks++;
          if (rx_data !== it.exp_d) begin
            errors++;
            $display("FAIL %s rx_data actual=%b expected=%b", it.tag, rx_data, it.exp_d);
          end
        end
        if (it.chk_c) begin
          checks++;
          if (carrier !== it.exp_c) begin
            errors++;
            $display("FAIL %s carrier actual=%b expected=%b", it.tag, carrier, it.exp_c);
          end
        end
      end
    end
  end

  task automatic expect_out(bit cd, bit ed, bit cc, bit ec, string tag);
    item_t it;
    it.chk_d = cd; it.exp_d = ed; it.chk_c = cc; it.exp_c = ec; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    @(negedge clk);
  endtask

  task automatic put_sample(real amp, real f);
    int c;
    c = 2048 + $rtoi(amp * $sin(ph));
    ph = ph + 2.0 * 3.14159265358979 * f / 9600.0;
    @(negedge clk);
    smp = c[11:0];
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_bit(bit b, real amp);
    for (int k = 0; k < 8; k++) put_sample(amp, b ? 1200.0 : 2200.0);
  endtask

  task automatic send_char(logic [7:0] ch, string tag);
    bit fr [11];
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++) fr[i+1] = ch[i];
    fr[9] = ^ch;
    fr[10] = 1'b1;
    for (int i = 0; i < 11; i++) begin
      send_bit(fr[i], 400.0);
      expect_out(1, fr[i], 1, 1, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out(1, 1, 1, 0, "R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1, 1, 1, 0, "R10 after reset release");
    rx_on = 1'b1;
    @(negedge clk);

    // strong mark then strong space
    send_bit(1, 400.0); expect_out(1, 1, 1, 1, "R1 R4 first mark");
    send_bit(1, 400.0); expect_out(1, 1, 1, 1, "R1 second mark");
    send_bit(0, 400.0); expect_out(1, 0, 1, 1, "R2 first space");
    send_bit(0, 400.0); expect_out(1, 0, 1, 1, "R2 second space");

    // characters with mixed tone changes
    send_char(8'hA5, "R3 char A5");
    send_char(8'h3C, "R3 char 3C");

    // mid-band level holds a set carrier
    send_bit(1, 170.0); expect_out(1, 1, 1, 1, "R6 hold high mark");
    send_bit(0, 170.0); expect_out(1, 0, 1, 1, "R6 hold high space");
    send_bit(1, 170.0); expect_out(1, 1, 1, 1, "R6 hold high mark2");

    // weak level clears carrier, output idles at mark
    send_bit(0, 100.0);
    send_bit(0, 100.0); expect_out(1, 1, 1, 0, "R5 R9 weak space");
    send_bit(0, 100.0); expect_out(1, 1, 1, 0, "R5 R9 weak space2");

    // mid-band level holds a cleared carrier
    send_bit(0, 170.0); expect_out(1, 1, 1, 0, "R6 R9 hold low");
    send_bit(0, 170.0); expect_out(1, 1, 1, 0, "R6 R9 hold low2");

    send_bit(0, 400.0); expect_out(1, 0, 1, 1, "R4 R2 strong again");

    // receive disabled: strong tone must be ignored
    rx_on = 1'b0;
    @(negedge clk);
    expect_out(1, 1, 1, 0, "R7 just disabled");
    for (int b = 0; b < 4; b++) begin
      send_bit(b[0], 400.0);
      expect_out(1, 1, 1, 0, "R7 disabled tone");
    end
    rx_on = 1'b1;
    @(negedge clk);
    expect_out(1, 1, 1, 0, "R8 re-entry cleared");
    put_sample(400.0, 2200.0);
    expect_out(1, 1, 1, 0, "R8 one sample after re-entry");
    for (int k = 0; k < 7; k++) put_sample(400.0, 2200.0);
    expect_out(1, 0, 1, 1, "R8 R2 space after re-entry");
    send_bit(1, 400.0); expect_out(1, 1, 1, 1, "R1 mark after re-entry");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule